// File: doc/BRIEF.md
# Append-Only KV Batch Staging Manager

This block sits beside the key/value store of a decoding accelerator and collects the entries produced one per decode step. Each arriving entry lands in one of two staging banks. Once a bank holds a full batch of 64 entries, the manager hands that bank to an external clustering engine. The engine reads the batch through a read port and returns one centroid word per cluster. Each batch yields four clusters, and each cluster takes one row of the clustered region. The manager assigns every batch four fresh, consecutive rows just past the rows already in use. It never gives a row out twice and never revisits a row it has handed out.

The two banks alternate. While the engine works on one bank, new entries keep filling the other, so the write port never has to wait. The manager keeps a table with one centroid word per batch. It also keeps a committed cluster count, which only grows in steps of four when the engine reports completion. A status output gives how many entries are not yet clustered, so a selector can attend to them densely. When the row region cannot take another batch, a sticky overflow flag rises and the manager refuses all further work.

Top module: `kv_append_mgr`

## Requirements
- R1: After reset, `unclustered`, `cluster_count`, `overflow` and `eng_start` are all 0, and every centroid table entry reads 0.
- R2: Every `tok_valid` cycle without overflow accepts one entry and raises `unclustered` by one. No engine start happens before a bank holds 64 entries.
- R3: The clock edge that accepts the 64th entry of a bank is followed, at the next edge, by `eng_start` going high for exactly one cycle.
- R4: Along with each start, `eng_base_row` gives the first of four consecutive rows. Successive batches get 0, 4, 8, ... with no gap and no reuse.
- R5: While a batch is being clustered, `eng_rd_data` at `eng_rd_idx` = i returns the (i+1)-th entry written into that batch.
- R6: Entries arriving while the engine is busy go into the other bank without loss. `unclustered` counts them, up to 128.
- R7: `cluster_count` rises by 4 at the edge that samples `eng_done` and at no other time. A start alone does not change it.
- R8: The edge that samples `eng_done` lowers `unclustered` by 64.
- R9: On `eng_done`, the 32-bit `eng_centroids` word (cluster j in bits 8j+7:8j) is stored at batch index `cluster_count`/4, which can be read on `sel_centroids` through `sel_batch`. An entry is never overwritten.
- R10: A batch that fills while the engine is busy waits. It is started at the edge after the busy batch's `eng_done` edge, in fill order.
- R11: When a full batch would need rows beyond `NUM_ROWS` (16), `overflow` rises one edge after the fill and stays high until reset. No start is issued, and later entries are ignored, so `unclustered` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | New entry present this cycle |
| tok_data | input | 16 | Entry payload |
| unclustered | output | 8 | Entries held but not yet clustered |
| eng_start | output | 1 | One-cycle start pulse to the clustering engine |
| eng_base_row | output | 5 | First row assigned to the started batch |
| eng_rd_idx | input | 6 | Entry index the engine reads in the busy batch |
| eng_rd_data | output | 16 | Entry at `eng_rd_idx` |
| eng_done | input | 1 | Engine finished the current batch (one cycle) |
| eng_centroids | input | 32 | Four centroid bytes returned with `eng_done` |
| cluster_count | output | 5 | Committed cluster rows |
| overflow | output | 1 | Row region exhausted (sticky) |
| sel_batch | input | 2 | Batch index for a centroid lookup |
| sel_centroids | output | 32 | Centroid word of `sel_batch` |

## Verification
The embedded properties assume the engine behaves correctly. It raises `eng_done` only while a batch it was given is still in progress. It also finishes each batch before the other bank has received 64 more entries and found its partner still busy, so the write port never meets a bank that cannot take data. The stimulus keeps to both rules. A behavioural engine in the bench acts only after it sees a start. It sends at most one full extra bank while busy, and it pulses done exactly once per batch. The overflow case feeds entries only after the region is full, when the no-refusal property is no longer armed.

// File: rtl/kv_stage_pkg.sv
// Package: shared types for the KV batch staging manager.
// Assumes exactly two staging banks used in alternation.
package kv_stage_pkg;
    // Life cycle of one staging bank.
    typedef enum logic [1:0] {
        BK_FREE = 2'd0,   // empty, not receiving
        BK_FILL = 2'd1,   // receiving new entries
        BK_WAIT = 2'd2,   // full, queued for the engine
        BK_BUSY = 2'd3    // being clustered
    } bank_st_t;
endpackage

// File: rtl/kv_stage_buf.sv
// Module: two staging banks of DEPTH entries each.
// One write port selects the bank being filled, and one asynchronous read
// port selects the bank being clustered. Assumes the controller never
// writes the bank the engine is reading.
module kv_stage_buf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wbank,
    input  logic [PTR_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rbank,
    input  logic [PTR_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rd_bank [2];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];

        // Store an accepted entry into this bank.
        always_ff @(posedge clk) begin
            if (we && (wbank == 1'(g)))
                mem[widx] <= wdata;
        end

        assign rd_bank[g] = mem[ridx];
    end

    assign rdata = rd_bank[rbank];
endmodule

// File: rtl/kv_centroid_tab.sv
// Module: per-batch centroid table, written once per finished batch.
// Assumes writes arrive with strictly increasing indices, one per batch.
module kv_centroid_tab #(
    parameter int WORD_W  = 32,
    parameter int BATCHES = 4,
    localparam int BIDX_W = (BATCHES > 1) ? $clog2(BATCHES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BIDX_W-1:0] widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [BIDX_W-1:0] ridx,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] tab [BATCHES];
    logic [BATCHES-1:0] filled;

    // Clear on reset; record each finished batch's centroid word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BATCHES; i++) tab[i] <= '0;
            filled <= '0;
        end else if (we) begin
            tab[widx]    <= wdata;
            filled[widx] <= 1'b1;
        end
    end

    assign rdata = tab[ridx];

    // R9: a centroid entry, once written, is never written again.
    assert_entry_immutable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !filled[widx]);
endmodule

// File: rtl/kv_batch_ctrl.sv
// Module: bank sequencing, engine handshake, row allocation and counters.
// Assumes eng_done comes only while a batch is busy, and the engine finishes
// before a second waiting batch would be needed.
module kv_batch_ctrl
    import kv_stage_pkg::*;
#(
    parameter int STG_DEPTH = 64,
    parameter int K         = 4,
    parameter int NUM_ROWS  = 16,
    localparam int PTR_W = $clog2(STG_DEPTH),
    localparam int ROW_W = $clog2(NUM_ROWS + 1),
    localparam int UNC_W = $clog2(2 * STG_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic             eng_done,
    output logic             wr_en,
    output logic             wr_bank,
    output logic [PTR_W-1:0] wr_idx,
    output logic             eng_start,
    output logic [ROW_W-1:0] eng_base_row,
    output logic             busy_bank,
    output logic             commit,
    output logic [ROW_W-1:0] cluster_count,
    output logic             overflow,
    output logic [UNC_W-1:0] unclustered
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(STG_DEPTH - 1);

    bank_st_t         st [2];
    logic             act;
    logic [PTR_W-1:0] wr_ptr;
    logic [ROW_W-1:0] rsv;
    logic [ROW_W-1:0] cnt;
    logic             ovf;
    logic             start_r;
    logic [ROW_W-1:0] base_r;
    logic             bsel;

    logic busy_any, wait_any, wb, accept, fill_last, act_nx, room;
    logic held0, held1;

    // Decode bank states into the decisions for this cycle.
    always_comb begin
        busy_any  = (st[0] == BK_BUSY) || (st[1] == BK_BUSY);
        wait_any  = (st[0] == BK_WAIT) || (st[1] == BK_WAIT);
        wb        = (st[act] == BK_WAIT) ? act : ~act;
        accept    = tok_valid && !ovf && (st[act] == BK_FILL);
        fill_last = accept && (wr_ptr == LAST);
        act_nx    = fill_last ? ~act : act;
        room      = ({1'b0, rsv} + (ROW_W + 1)'(K)) <= (ROW_W + 1)'(NUM_ROWS);
        held0     = (st[0] == BK_WAIT) || (st[0] == BK_BUSY);
        held1     = (st[1] == BK_WAIT) || (st[1] == BK_BUSY);
    end

    // Advance bank states, pointers, row reservation and committed count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st[0]   <= BK_FILL;
            st[1]   <= BK_FREE;
            act     <= 1'b0;
            wr_ptr  <= '0;
            rsv     <= '0;
            cnt     <= '0;
            ovf     <= 1'b0;
            start_r <= 1'b0;
            base_r  <= '0;
            bsel    <= 1'b0;
        end else begin
            start_r <= 1'b0;
            if (accept) begin
                if (fill_last) begin
                    st[act] <= BK_WAIT;
                    wr_ptr  <= '0;
                    act     <= ~act;
                    if (st[~act] == BK_FREE) st[~act] <= BK_FILL;
                end else begin
                    wr_ptr <= wr_ptr + 1'b1;
                end
            end
            if (wait_any && !busy_any && !ovf) begin
                if (room) begin
                    st[wb]  <= BK_BUSY;
                    bsel    <= wb;
                    start_r <= 1'b1;
                    base_r  <= rsv;
                    rsv     <= rsv + ROW_W'(K);
                end else begin
                    ovf <= 1'b1;
                end
            end
            if (eng_done && busy_any) begin
                st[bsel] <= (bsel == act_nx) ? BK_FILL : BK_FREE;
                cnt      <= cnt + ROW_W'(K);
            end
        end
    end

    assign wr_en         = accept;
    assign wr_bank       = act;
    assign wr_idx        = wr_ptr;
    assign eng_start     = start_r;
    assign eng_base_row  = base_r;
    assign busy_bank     = bsel;
    assign commit        = eng_done && busy_any;
    assign cluster_count = cnt;
    assign overflow      = ovf;
    assign unclustered   = UNC_W'(wr_ptr) + (held0 ? UNC_W'(STG_DEPTH) : '0)
                                          + (held1 ? UNC_W'(STG_DEPTH) : '0);

    // R3: the start request is a single-cycle pulse.
    assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_r |=> !start_r);
    // R4: a started batch always fits inside the row region.
    assert_rows_fit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_r |-> ({1'b0, base_r} + (ROW_W + 1)'(K)) <= (ROW_W + 1)'(NUM_ROWS));
    // R7: the committed count moves only after a done handshake.
    assert_count_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_done |=> $stable(cnt));
    // R7: the engine reports completion only while it holds a batch.
    assert_done_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> busy_any);
    // R6: without overflow, the write port never meets a bank that cannot take data.
    assert_no_refused_token_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !ovf) |-> (st[act] == BK_FILL));
    // R6: never more than two banks' worth of pending entries.
    assert_unclustered_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        unclustered <= UNC_W'(2 * STG_DEPTH));
    // R11: overflow is sticky.
    assert_overflow_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R11: no batch is started once the region is exhausted.
    assert_no_start_after_ovf_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> !start_r);
endmodule

// File: rtl/kv_append_mgr.sv
// Module: top of the append-only KV batch staging manager.
// Wires the staging banks, the batch controller and the centroid table.
// Assumes a well-behaved clustering engine on the start/done handshake.
module kv_append_mgr #(
    parameter int DATA_W    = 16,
    parameter int STG_DEPTH = 64,
    parameter int K         = 4,
    parameter int CEN_W     = 8,
    parameter int NUM_ROWS  = 16,
    localparam int PTR_W   = $clog2(STG_DEPTH),
    localparam int ROW_W   = $clog2(NUM_ROWS + 1),
    localparam int UNC_W   = $clog2(2 * STG_DEPTH + 1),
    localparam int BATCHES = NUM_ROWS / K,
    localparam int BIDX_W  = (BATCHES > 1) ? $clog2(BATCHES) : 1,
    localparam int WORD_W  = K * CEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [DATA_W-1:0] tok_data,
    output logic [UNC_W-1:0]  unclustered,
    output logic              eng_start,
    output logic [ROW_W-1:0]  eng_base_row,
    input  logic [PTR_W-1:0]  eng_rd_idx,
    output logic [DATA_W-1:0] eng_rd_data,
    input  logic              eng_done,
    input  logic [WORD_W-1:0] eng_centroids,
    output logic [ROW_W-1:0]  cluster_count,
    output logic              overflow,
    input  logic [BIDX_W-1:0] sel_batch,
    output logic [WORD_W-1:0] sel_centroids
);
    logic             wr_en, wr_bank, busy_bank, commit;
    logic [PTR_W-1:0] wr_idx;
    logic [BIDX_W-1:0] tab_widx;

    kv_batch_ctrl #(.STG_DEPTH(STG_DEPTH), .K(K), .NUM_ROWS(NUM_ROWS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .eng_done(eng_done),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
        .eng_start(eng_start), .eng_base_row(eng_base_row),
        .busy_bank(busy_bank), .commit(commit), .cluster_count(cluster_count),
        .overflow(overflow), .unclustered(unclustered)
    );

    kv_stage_buf #(.DATA_W(DATA_W), .DEPTH(STG_DEPTH)) u_buf (
        .clk(clk), .we(wr_en), .wbank(wr_bank), .widx(wr_idx), .wdata(tok_data),
        .rbank(busy_bank), .ridx(eng_rd_idx), .rdata(eng_rd_data)
    );

    assign tab_widx = BIDX_W'(cluster_count / ROW_W'(K));

    kv_centroid_tab #(.WORD_W(WORD_W), .BATCHES(BATCHES)) u_tab (
        .clk(clk), .rst_n(rst_n), .we(commit), .widx(tab_widx),
        .wdata(eng_centroids), .ridx(sel_batch), .rdata(sel_centroids)
    );
endmodule

// File: tb/kv_append_mgr_test.sv
`timescale 1ns/1ps
// Bench: scoreboard of staged entries and expected starts, behavioural engine.
module kv_append_mgr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_valid = 1'b0;
    logic [15:0] tok_data = '0;
    logic [7:0]  unclustered;
    logic        eng_start;
    logic [4:0]  eng_base_row;
    logic [5:0]  eng_rd_idx = '0;
    logic [15:0] eng_rd_data;
    logic        eng_done = 1'b0;
    logic [31:0] eng_centroids = '0;
    logic [4:0]  cluster_count;
    logic        overflow;
    logic [1:0]  sel_batch = '0;
    logic [31:0] sel_centroids;

    int checks = 0;
    int errors = 0;
    int seq = 0;
    logic [15:0] tok_q[$];
    logic [4:0]  start_q[$];

    always #2 clk = ~clk;

    kv_append_mgr uut (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_data(tok_data),
        .unclustered(unclustered), .eng_start(eng_start), .eng_base_row(eng_base_row),
        .eng_rd_idx(eng_rd_idx), .eng_rd_data(eng_rd_data), .eng_done(eng_done),
        .eng_centroids(eng_centroids), .cluster_count(cluster_count),
        .overflow(overflow), .sel_batch(sel_batch), .sel_centroids(sel_centroids)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: one entry per cycle; keep accepted ones and any expected start.
    task automatic send(input int n, input bit keep, input bit exp_start, input logic [4:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tok_valid = 1'b1;
            tok_data  = 16'hA000 + 16'(seq);
            seq++;
            if (keep) tok_q.push_back(tok_data);
            if (exp_start && i == n - 1) start_q.push_back(base);
        end
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    // Engine model: read the busy batch, compare, then report done.
    task automatic serve(input logic [31:0] cen);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            eng_rd_idx = 6'(i);
            #1;
            if (tok_q.size() == 0) check("R5 data queue empty", 32'd1, 32'd0);
            else check("R5 batch data", {16'h0, eng_rd_data}, {16'h0, tok_q.pop_front()});
        end
        @(negedge clk);
        eng_done = 1'b1;
        eng_centroids = cen;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    // Monitor: each observed start must match the next expected base row.
    always @(negedge clk) begin
        if (rst_n && eng_start) begin
            if (start_q.size() == 0) check("R3 unexpected start", 32'd1, 32'd0);
            else check("R4 base row", {27'h0, eng_base_row}, {27'h0, start_q.pop_front()});
        end
    end

    task automatic read_cen(input logic [1:0] b, input logic [31:0] exp, input string req);
        sel_batch = b;
        #1;
        check(req, sel_centroids, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 unclustered", {24'h0, unclustered}, 32'd0);
        check("R1 cluster_count", {27'h0, cluster_count}, 32'd0);
        check("R1 overflow", {31'h0, overflow}, 32'd0);
        check("R1 eng_start", {31'h0, eng_start}, 32'd0);
        read_cen(2'd0, 32'h0, "R1 centroid entry");

        // R2 partial fill, no start yet
        send(10, 1'b1, 1'b0, 5'd0);
        check("R2 count after 10", {24'h0, unclustered}, 32'd10);
        send(54, 1'b1, 1'b1, 5'd0);
        check("R2 count at full bank", {24'h0, unclustered}, 32'd64);
        check("R3 no start at fill edge", {31'h0, eng_start}, 32'd0);
        @(negedge clk);
        check("R3 start one edge later", {31'h0, eng_start}, 32'd1);
        check("R7 count unchanged by start", {27'h0, cluster_count}, 32'd0);

        // R6 entries during busy go to the other bank
        send(5, 1'b1, 1'b0, 5'd0);
        check("R6 counted during busy", {24'h0, unclustered}, 32'd69);
        serve(32'h11223344);
        check("R7 count after done", {27'h0, cluster_count}, 32'd4);
        check("R8 drop by 64", {24'h0, unclustered}, 32'd5);
        read_cen(2'd0, 32'h11223344, "R9 batch 0 stored");

        // R10 second bank fills, third batch waits behind it
        send(59, 1'b1, 1'b1, 5'd4);
        send(64, 1'b1, 1'b1, 5'd8);
        check("R6 both banks held", {24'h0, unclustered}, 32'd128);
        serve(32'h55667788);
        check("R10 no start at done edge", {31'h0, eng_start}, 32'd0);
        @(negedge clk);
        check("R10 waiting batch starts", {31'h0, eng_start}, 32'd1);
        check("R7 count two batches", {27'h0, cluster_count}, 32'd8);
        read_cen(2'd0, 32'h11223344, "R9 batch 0 unchanged");
        read_cen(2'd1, 32'h55667788, "R9 batch 1 stored");
        serve(32'h99AABBCC);
        check("R8 all clustered", {24'h0, unclustered}, 32'd0);

        // Fourth batch fills the region exactly
        send(64, 1'b1, 1'b1, 5'd12);
        @(negedge clk);
        serve(32'hDDEEFF00);
        check("R7 region full", {27'h0, cluster_count}, 32'd16);
        check("R11 no overflow at exact fit", {31'h0, overflow}, 32'd0);

        // R11 one more batch cannot fit
        send(64, 1'b0, 1'b0, 5'd0);
        check("R11 overflow not yet", {31'h0, overflow}, 32'd0);
        @(negedge clk);
        check("R11 overflow raised", {31'h0, overflow}, 32'd1);
        send(3, 1'b0, 1'b0, 5'd0);
        check("R11 entries ignored", {24'h0, unclustered}, 32'd64);
        repeat (5) @(negedge clk);
        check("R11 overflow sticky", {31'h0, overflow}, 32'd1);
        check("R11 count frozen", {27'h0, cluster_count}, 32'd16);
        read_cen(2'd3, 32'hDDEEFF00, "R9 batch 3 stored");
        check("R4 all starts seen", 32'(start_q.size()), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule